// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache misses that are still waiting for data, so that a non-blocking cache can go on serving hits in the meantime. Each register in the file describes one outstanding block. It holds the block address, the cache set the block will be written into, a destination tag for every word that a load is waiting on, and any store data that arrived for that block before the fill.

When a miss arrives, the file compares its block address against every busy register. If the block is new, the lowest-numbered free register is claimed and a single request goes to the next level, tagged with the register number. If the block is already outstanding, the miss is folded into the existing register and no new request is sent. Responses carry the register number and may return in any order. One cycle after a response, the block emits a fill for the cache set and a forwarding bundle that lists, word by word, which destinations receive data. The register is then released.

Top module: `mshr_file`

## Requirements
- R1: A miss to a block that no busy entry holds, while a free entry exists, is accepted in the same cycle. It raises `req_valid` with `req_blk` equal to the miss block and `req_tag` equal to the lowest-numbered free entry.
- R2: A miss to a block that a busy entry already holds is merged into that entry. It raises neither a stall nor `req_valid`, and only one busy entry ever holds a given block.
- R3: When every entry is busy and a miss names a block that none holds, `miss_stall` is 1 and `req_valid` is 0.
- R4: A load miss to a word that already has a load destination recorded in the matching entry stalls if its destination differs, and is accepted if it is the same. Store misses never stall for this reason.
- R5: A store miss marks its word in the entry and records its data. On fill, each marked word carries the store data and each unmarked word carries the response data. A later store to the same word replaces the earlier store data.
- R6: A response whose tag names a busy entry makes `fill_valid` 1 in the next cycle, for exactly one cycle. That cycle carries the entry's set index and block, the merged block data (word w in bits w*DATA_W upward), `fwd_mask` bit w set for each word with a recorded load, and `fwd_dest` field w (bits w*DEST_W upward) holding that word's destination, or 0 where no load is recorded.
- R7: An entry is freed by its response and can be allocated again afterwards. Responses may arrive in any order.
- R8: A miss to a block whose entry receives its response in the same cycle stalls.
- R9: After reset no entry is busy, `fill_valid` and `req_valid` are 0, and no stall is raised while `miss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented |
| miss_is_store | input | 1 | 1 for a store miss, 0 for a load miss |
| miss_blk | input | BLK_W | Block address of the miss |
| miss_idx | input | IDX_W | Cache set the block will fill |
| miss_word | input | log2(WORDS) | Word within the block |
| miss_dest | input | DEST_W | Load destination tag |
| miss_wdata | input | DATA_W | Store data |
| miss_stall | output | 1 | Miss not accepted this cycle |
| req_valid | output | 1 | Next-level request for a new block |
| req_blk | output | BLK_W | Block address requested |
| req_tag | output | log2(N_ENT) | Entry number used as response tag |
| resp_valid | input | 1 | Block data returned |
| resp_tag | input | log2(N_ENT) | Entry the data belongs to |
| resp_data | input | WORDS*DATA_W | Returned block |
| fill_valid | output | 1 | Fill and forwarding bundle valid |
| fill_idx | output | IDX_W | Set to write |
| fill_blk | output | BLK_W | Block address filled |
| fill_data | output | WORDS*DATA_W | Merged block; word w is also the forwarded data for word w |
| fwd_mask | output | WORDS | Words with a waiting load |
| fwd_dest | output | WORDS*DEST_W | Destination per word |

## Verification
The bench builds the block with four entries, four words per block, 8-bit block addresses and 16-bit words. With this size, every entry can be filled until the file stalls, every word position can be used for loads and stores, and out-of-order responses recycle each entry several times. A reference model in the bench predicts the stall, the request tag and the merged fill for each step. The sweep places the load and store words at every rotation of word positions, and separate cases cover destination clashes, repeated stores to one word, and a miss that lands in the same cycle as its own response.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic [1:0] {
        HOLD_NONE   = 2'd0,
        HOLD_FULL   = 2'd1,
        HOLD_CLASH  = 2'd2,
        HOLD_RETIRE = 2'd3
    } hold_why_e;

    function automatic logic is_hold(input hold_why_e why);
        return why != HOLD_NONE;
    endfunction

endpackage

// File: rtl/mshr_match.sv
module mshr_match #(
    parameter int unsigned N_ENT = 4,
    parameter int unsigned BLK_W = 8,
    localparam int unsigned TAG_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]       busy,
    input  logic [N_ENT*BLK_W-1:0] blk_flat,
    input  logic [BLK_W-1:0]       probe_blk,
    output logic                   hit_any,
    output logic [TAG_W-1:0]       hit_tag
);
    logic [N_ENT-1:0] hit_vec;

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec[e] = busy[e] && (blk_flat[e*BLK_W +: BLK_W] == probe_blk);
    end

    always_comb begin
        hit_tag = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (hit_vec[e]) hit_tag = TAG_W'(e);
        end
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/mshr_alloc.sv
module mshr_alloc #(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned TAG_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] busy,
    output logic             free_any,
    output logic [TAG_W-1:0] free_tag
);
    always_comb begin
        free_any = 1'b0;
        free_tag = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (!busy[e]) begin
                free_any = 1'b1;
                free_tag = TAG_W'(e);
            end
        end
    end
endmodule

// File: rtl/mshr_merge.sv
module mshr_merge #(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic [WORDS*DATA_W-1:0] mem_data,
    input  logic [WORDS-1:0]        st_mark,
    input  logic [WORDS*DATA_W-1:0] st_data,
    output logic [WORDS*DATA_W-1:0] merged
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign merged[w*DATA_W +: DATA_W] = st_mark[w] ? st_data[w*DATA_W +: DATA_W]
                                                       : mem_data[w*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int unsigned N_ENT  = 4,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned BLK_W  = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DEST_W = 5,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned TAG_W  = $clog2(N_ENT),
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned LINE_W = WORDS * DATA_W,
    localparam int unsigned DVEC_W = WORDS * DEST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic              miss_is_store,
    input  logic [BLK_W-1:0]  miss_blk,
    input  logic [IDX_W-1:0]  miss_idx,
    input  logic [WSEL_W-1:0] miss_word,
    input  logic [DEST_W-1:0] miss_dest,
    input  logic [DATA_W-1:0] miss_wdata,
    output logic              miss_stall,
    output logic              req_valid,
    output logic [BLK_W-1:0]  req_blk,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    input  logic [LINE_W-1:0] resp_data,
    output logic              fill_valid,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [BLK_W-1:0]  fill_blk,
    output logic [LINE_W-1:0] fill_data,
    output logic [WORDS-1:0]  fwd_mask,
    output logic [DVEC_W-1:0] fwd_dest
);
    logic [N_ENT-1:0]       busy_q;
    logic [BLK_W-1:0]       blk_q   [N_ENT];
    logic [IDX_W-1:0]       idx_q   [N_ENT];
    logic [WORDS-1:0]       ldmark_q[N_ENT];
    logic [DVEC_W-1:0]      dest_q  [N_ENT];
    logic [WORDS-1:0]       stmark_q[N_ENT];
    logic [LINE_W-1:0]      sdata_q [N_ENT];
    logic [N_ENT*BLK_W-1:0] blk_flat;

    always_comb begin
        for (int e = 0; e < N_ENT; e++) blk_flat[e*BLK_W +: BLK_W] = blk_q[e];
    end

    logic             hit_any, free_any;
    logic [TAG_W-1:0] hit_tag, free_tag, tgt;

    mshr_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_match (
        .busy(busy_q), .blk_flat(blk_flat), .probe_blk(miss_blk),
        .hit_any(hit_any), .hit_tag(hit_tag)
    );

    mshr_alloc #(.N_ENT(N_ENT)) u_alloc (
        .busy(busy_q), .free_any(free_any), .free_tag(free_tag)
    );

    logic [LINE_W-1:0] merged;

    mshr_merge #(.WORDS(WORDS), .DATA_W(DATA_W)) u_merge (
        .mem_data(resp_data), .st_mark(stmark_q[resp_tag]),
        .st_data(sdata_q[resp_tag]), .merged(merged)
    );

    // Classify the incoming miss
    hold_why_e         why;
    logic [DEST_W-1:0] prior_dest;
    logic              clash, retiring, accept, primary;

    assign prior_dest = dest_q[hit_tag][miss_word*DEST_W +: DEST_W];
    assign clash      = !miss_is_store && ldmark_q[hit_tag][miss_word] && (prior_dest != miss_dest);
    assign retiring   = resp_valid && (resp_tag == hit_tag);

    always_comb begin
        why = HOLD_NONE;
        if (miss_valid) begin
            if (hit_any) begin
                if (retiring)   why = HOLD_RETIRE;
                else if (clash) why = HOLD_CLASH;
            end else if (!free_any) begin
                why = HOLD_FULL;
            end
        end
    end

    assign miss_stall = is_hold(why);
    assign accept     = miss_valid && !miss_stall;
    assign primary    = accept && !hit_any;
    assign tgt        = hit_any ? hit_tag : free_tag;
    assign req_valid  = primary;
    assign req_blk    = miss_blk;
    assign req_tag    = free_tag;

    // Next contents of the target entry
    logic [WORDS-1:0]  nx_ldmark, nx_stmark;
    logic [DVEC_W-1:0] nx_dest;
    logic [LINE_W-1:0] nx_sdata;

    always_comb begin
        nx_ldmark = primary ? '0 : ldmark_q[tgt];
        nx_stmark = primary ? '0 : stmark_q[tgt];
        nx_dest   = primary ? '0 : dest_q[tgt];
        nx_sdata  = primary ? '0 : sdata_q[tgt];
        if (miss_is_store) begin
            nx_stmark[miss_word]                    = 1'b1;
            nx_sdata[miss_word*DATA_W +: DATA_W]    = miss_wdata;
        end else begin
            nx_ldmark[miss_word]                    = 1'b1;
            nx_dest[miss_word*DEST_W +: DEST_W]     = miss_dest;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= '0;
            fill_valid <= 1'b0;
            fill_idx   <= '0;
            fill_blk   <= '0;
            fill_data  <= '0;
            fwd_mask   <= '0;
            fwd_dest   <= '0;
            for (int e = 0; e < N_ENT; e++) begin
                blk_q[e]    <= '0;
                idx_q[e]    <= '0;
                ldmark_q[e] <= '0;
                dest_q[e]   <= '0;
                stmark_q[e] <= '0;
                sdata_q[e]  <= '0;
            end
        end else begin
            fill_valid <= 1'b0;
            if (resp_valid && busy_q[resp_tag]) begin
                fill_valid       <= 1'b1;
                fill_idx         <= idx_q[resp_tag];
                fill_blk         <= blk_q[resp_tag];
                fill_data        <= merged;
                fwd_mask         <= ldmark_q[resp_tag];
                fwd_dest         <= dest_q[resp_tag];
                busy_q[resp_tag] <= 1'b0;
            end
            if (accept) begin
                if (primary) begin
                    busy_q[tgt] <= 1'b1;
                    blk_q[tgt]  <= miss_blk;
                    idx_q[tgt]  <= miss_idx;
                end
                ldmark_q[tgt] <= nx_ldmark;
                stmark_q[tgt] <= nx_stmark;
                dest_q[tgt]   <= nx_dest;
                sdata_q[tgt]  <= nx_sdata;
            end
        end
    end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int unsigned N_ENT = 4,
    parameter int unsigned BLK_W = 8,
    parameter int unsigned TAG_W = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   miss_valid,
    input logic                   miss_stall,
    input logic                   req_valid,
    input logic [TAG_W-1:0]       req_tag,
    input logic                   resp_valid,
    input logic [TAG_W-1:0]       resp_tag,
    input logic                   fill_valid,
    input logic [N_ENT-1:0]       busy,
    input logic [N_ENT*BLK_W-1:0] blk_flat
);
    // R1
    req_accepted_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (miss_valid && !miss_stall));

    // R1
    req_claims_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> busy[$past(req_tag)]);

    // R3
    full_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (&busy) |-> !req_valid);

    // R6
    fill_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && busy[resp_tag]) |=> fill_valid);

    // R6
    fill_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> $past(resp_valid));

    for (genvar i = 0; i < N_ENT; i++) begin : g_i
        for (genvar j = i + 1; j < N_ENT; j++) begin : g_j
            // R2
            block_unique_chk: assert property (@(posedge clk) disable iff (rst)
                (busy[i] && busy[j]) |-> (blk_flat[i*BLK_W +: BLK_W] != blk_flat[j*BLK_W +: BLK_W]));
        end
    end
endmodule

bind mshr_file mshr_file_chk #(.N_ENT(N_ENT), .BLK_W(BLK_W), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_stall(miss_stall),
    .req_valid(req_valid), .req_tag(req_tag), .resp_valid(resp_valid),
    .resp_tag(resp_tag), .fill_valid(fill_valid), .busy(busy_q), .blk_flat(blk_flat)
);

// File: tb/mshr_file_test.sv
module mshr_file_test;
    localparam int CLK_P = 10;
    localparam int NE = 4;
    localparam int WD = 4;
    localparam int BW = 8;
    localparam int IW = 4;
    localparam int DW = 5;
    localparam int DAW = 16;

    logic clk = 0;
    logic rst = 1;
    logic miss_valid = 0, miss_is_store = 0;
    logic [BW-1:0] miss_blk = '0;
    logic [IW-1:0] miss_idx = '0;
    logic [1:0] miss_word = '0;
    logic [DW-1:0] miss_dest = '0;
    logic [DAW-1:0] miss_wdata = '0;
    logic miss_stall, req_valid;
    logic [BW-1:0] req_blk;
    logic [1:0] req_tag;
    logic resp_valid = 0;
    logic [1:0] resp_tag = '0;
    logic [WD*DAW-1:0] resp_data = '0;
    logic fill_valid;
    logic [IW-1:0] fill_idx;
    logic [BW-1:0] fill_blk;
    logic [WD*DAW-1:0] fill_data;
    logic [WD-1:0] fwd_mask;
    logic [WD*DW-1:0] fwd_dest;

    always #(CLK_P/2) clk = ~clk;

    mshr_file #(.N_ENT(NE), .WORDS(WD), .BLK_W(BW), .IDX_W(IW), .DEST_W(DW), .DATA_W(DAW)) uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_is_store(miss_is_store),
        .miss_blk(miss_blk), .miss_idx(miss_idx), .miss_word(miss_word), .miss_dest(miss_dest),
        .miss_wdata(miss_wdata), .miss_stall(miss_stall), .req_valid(req_valid),
        .req_blk(req_blk), .req_tag(req_tag), .resp_valid(resp_valid), .resp_tag(resp_tag),
        .resp_data(resp_data), .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_blk(fill_blk),
        .fill_data(fill_data), .fwd_mask(fwd_mask), .fwd_dest(fwd_dest)
    );

    int n_cmp = 0, n_bad = 0, seq = 0;
    bit done = 0;

    // Reference model
    bit mb[NE];
    int mblk[NE], midx[NE];
    bit mdv[NE][WD], msv[NE][WD];
    int mdest[NE][WD], msd[NE][WD];

    task automatic check(input string rq, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [WD*DAW-1:0] line_for(input int t, input int s);
        logic [WD*DAW-1:0] v;
        for (int w = 0; w < WD; w++) v[w*DAW +: DAW] = 16'(s * 256 + t * 16 + w + 1);
        return v;
    endfunction

    task automatic do_miss(input bit st, input int blk, input int idx, input int word,
                           input int dest, input int data);
        int hit = -1;
        int fr = -1;
        int e;
        string rq;
        bit es, er;
        for (int k = 0; k < NE; k++) if (mb[k] && mblk[k] == blk) hit = k;
        for (int k = NE - 1; k >= 0; k--) if (!mb[k]) fr = k;
        er = 0;
        if (hit >= 0) begin
            if (!st && mdv[hit][word] && mdest[hit][word] != dest) begin es = 1; rq = "R4"; end
            else begin es = 0; rq = st ? "R5" : "R2"; end
        end else if (fr < 0) begin
            es = 1; rq = "R3";
        end else begin
            es = 0; er = 1; rq = "R1";
        end
        @(negedge clk);
        miss_valid = 1; miss_is_store = st; miss_blk = 8'(blk); miss_idx = 4'(idx);
        miss_word = 2'(word); miss_dest = 5'(dest); miss_wdata = 16'(data);
        #1;
        check(rq, "stall", longint'(miss_stall), longint'(es));
        check(rq, "req_valid", longint'(req_valid), longint'(er));
        if (er) begin
            check(rq, "req_tag", longint'(req_tag), longint'(fr));
            check(rq, "req_blk", longint'(req_blk), longint'(blk));
        end
        @(posedge clk);
        #1 miss_valid = 0;
        if (!es) begin
            e = (hit >= 0) ? hit : fr;
            if (hit < 0) begin
                mb[e] = 1; mblk[e] = blk; midx[e] = idx;
                for (int w = 0; w < WD; w++) begin
                    mdv[e][w] = 0; msv[e][w] = 0; mdest[e][w] = 0; msd[e][w] = 0;
                end
            end
            if (st) begin msv[e][word] = 1; msd[e][word] = data; end
            else begin mdv[e][word] = 1; mdest[e][word] = dest; end
        end
    endtask

    task automatic check_fill(input int t, input logic [WD*DAW-1:0] rd);
        logic [WD*DAW-1:0] exp_d;
        logic [WD-1:0] exp_m;
        logic [WD*DW-1:0] exp_dst;
        for (int w = 0; w < WD; w++) begin
            exp_d[w*DAW +: DAW] = msv[t][w] ? 16'(msd[t][w]) : rd[w*DAW +: DAW];
            exp_m[w] = mdv[t][w];
            exp_dst[w*DW +: DW] = 5'(mdest[t][w]);
        end
        check("R6", "fill_valid", longint'(fill_valid), 1);
        check("R6", "fill_idx", longint'(fill_idx), longint'(midx[t]));
        check("R6", "fill_blk", longint'(fill_blk), longint'(mblk[t]));
        check("R5", "fill_data", longint'(fill_data), longint'(exp_d));
        check("R6", "fwd_mask", longint'(fwd_mask), longint'(exp_m));
        check("R6", "fwd_dest", longint'(fwd_dest), longint'(exp_dst));
        mb[t] = 0;
        @(negedge clk);
        check("R6", "fill_valid one cycle", longint'(fill_valid), 0);
    endtask

    task automatic do_resp(input int t);
        logic [WD*DAW-1:0] rd;
        seq++;
        rd = line_for(t, seq);
        @(negedge clk);
        resp_valid = 1; resp_tag = 2'(t); resp_data = rd;
        @(posedge clk);
        #1 resp_valid = 0;
        @(negedge clk);
        check_fill(t, rd);
    endtask

    function automatic int find_tag(input int blk);
        for (int k = 0; k < NE; k++) if (mb[k] && mblk[k] == blk) return k;
        return 0;
    endfunction

    initial begin
        for (int k = 0; k < NE; k++) mb[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R9 reset state
        check("R9", "fill_valid", longint'(fill_valid), 0);
        check("R9", "req_valid", longint'(req_valid), 0);
        check("R9", "stall", longint'(miss_stall), 0);

        // R1 R2 R3 R5 R6 R7 sweep over word rotations
        for (int w = 0; w < WD; w++) begin
            for (int e = 0; e < NE; e++) begin
                do_miss(0, 16*w + e + 1, (e + w) % 16, w, e + 1, 0);
                do_miss(1, 16*w + e + 1, 0, (w + 1) % WD, 0, 16'hC000 + 16*w + e);
                do_miss(0, 16*w + e + 1, 0, (w + 2) % WD, e + 9, 0);
            end
            do_miss(0, 16*w + 15, 1, w, 3, 0);          // R3 all busy
            do_resp(2);                                   // R7 out of order
            do_miss(0, 16*w + 15, 1, w, 3, 0);          // reuse freed entry
            do_resp(0);
            do_resp(3);
            do_resp(1);
            do_resp(2);
        end

        // R4 destination clash and R5 repeated store
        do_miss(0, 8'hF0, 5, 1, 3, 0);
        do_miss(0, 8'hF0, 5, 1, 4, 0);
        do_miss(0, 8'hF0, 5, 1, 3, 0);
        do_miss(1, 8'hF0, 5, 1, 0, 16'h1111);
        do_miss(1, 8'hF0, 5, 2, 0, 16'h2222);
        do_miss(1, 8'hF0, 5, 2, 0, 16'h3333);
        do_resp(find_tag(8'hF0));

        // R8 miss meets its own response
        do_miss(0, 8'h77, 9, 0, 6, 0);
        begin
            int t;
            logic [WD*DAW-1:0] rd;
            t = find_tag(8'h77);
            seq++;
            rd = line_for(t, seq);
            @(negedge clk);
            resp_valid = 1; resp_tag = 2'(t); resp_data = rd;
            miss_valid = 1; miss_is_store = 0; miss_blk = 8'h77; miss_word = 2'd3; miss_dest = 5'd7;
            #1;
            check("R8", "stall", longint'(miss_stall), 1);
            check("R8", "req_valid", longint'(req_valid), 0);
            @(posedge clk);
            #1 resp_valid = 0; miss_valid = 0;
            @(negedge clk);
            check_fill(t, rd);
        end
        do_miss(0, 8'h77, 9, 3, 7, 0);                   // R7 reallocated
        do_resp(find_tag(8'h77));

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule